// File: doc/BRIEF.md
# One-Pulse Compare/Capture Timer

A 16-bit up-counting timer with one capture input and two compare outputs, programmed through a small byte-wide register port. The counter advances on a tick that comes from a free-running prescaler: a fixed division of the system clock, or an external tick strobe. Capture channel 1 synchronises its input, detects an edge of programmable polarity and stores the counter value. Compare channels 1 and 2 watch the counter and drive their pins when it reaches the programmed value.

In one-pulse mode an active capture edge restarts the counter at 0xFFFC and opens a pulse on compare pin 1. The pulse closes when the counter reaches compare value 1, so the pulse width is set entirely by that register. Forced-level mode writes the programmed pin levels straight onto the compare pins. A PWM select bit is kept only as a priority input that suppresses one-pulse mode. Byte-access interlocks let software read or write 16-bit values safely: writing a compare high byte suspends that compare, and reading the capture high byte suspends capture.

Registers are at `reg_addr`: 0 control A, 1 control B, 2 status, 3/4 counter high/low (read only), 5/6 compare 1 high/low, 7/8 compare 2 high/low, 9/10 capture high/low (read only). Control A bits: [0] after-level, [1] pulse-level, [2] force pin 1, [3] force pin 2, [4] rising-edge select, [5] global capture interrupt enable, [6] compare interrupt enable. Control B bits: [0] pin 1 enable, [1] pin 2 enable, [2] one-pulse, [3] PWM, [5:4] tick select, [6] channel-1 capture interrupt enable. Status bits: [0] capture flag, [1] compare 1 flag, [2] compare 2 flag.

Top module: `occ_timer`

## Requirements
- R1: After reset the counter is 0, status is 0, both compare registers are 0xFFFF, the capture register is 0, control B reads 0x30 (external tick selected), control A reads 0, and cmp1_out, cmp2_out and irq are low.
- R2: Tick select control B[5:4] = 0, 1, 2 advances the counter once every 2, 4 or 8 clocks; 3 advances it on each clock in which ext_tick is high; without a tick and without a one-pulse start the counter holds.
- R3: With control B[2] set and B[3] clear, an active capture edge loads the counter with 0xFFFC, loads the capture register with 0xFFFC, sets status[0], and drives pin 1 to control A[1] on the next clock.
- R4: In one-pulse mode pin 1 takes control A[0] on the clock at which the counter advances to compare value 1, so the pulse lasts (C1 - 0xFFFC) mod 65536 ticks; when C1 is 0xFFFC the pulse lasts 0xFFFC ticks.
- R5: In one-pulse mode status[1] is never set by hardware, while status[2] is still set when the counter advances to compare value 2.
- R6: When control B[3] is set, a capture edge never reloads the counter nor opens a pulse, even with B[2] set; the capture stores the running counter value and sets status[0].
- R7: With control A[2] set and B[2], B[3] clear, pin 1 follows control A[0] one clock after it is written; in one-pulse mode A[2] has no effect. Control A[3] makes pin 2 follow A[1] in every mode. Forcing sets no status flag.
- R8: Writing a compare high byte (address 5 or 7) stops that channel from matching until its low byte (6 or 8) is written.
- R9: Reading the capture high byte (address 9) blocks captures and one-pulse starts until the capture low byte (10) is read.
- R10: Control A[4] = 1 makes a rising capture edge active, 0 a falling edge; the other edge captures nothing.
- R11: irq is high when status[0] is set with control A[5] or control B[6] set, or when status[1] or status[2] is set with control A[6] set; writing 1 to a status bit clears it, writing 0 leaves it.
- R12: cmp1_out and cmp2_out show the pin levels only while control B[0] and B[1] are set respectively, and are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one clock per access |
| reg_rd | input | 1 | Read strobe, one clock per access (drives interlocks) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| cap_in | input | 1 | Capture input 1, asynchronous |
| ext_tick | input | 1 | External tick strobe, synchronous to clk |
| cmp1_out | output | 1 | Compare pin 1 |
| cmp2_out | output | 1 | Compare pin 2 |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest state to reach from the ports is a counter sitting at a chosen value next to a compare value, because the counter is read-only and free-running. The bench selects the external tick, holds ext_tick low to freeze the count, and uses a one-pulse start edge as the only way to load the counter with 0xFFFC; single ext_tick strobes then step it onto the compare value while the interlocks are set or cleared. The pulse-width sweep runs with ext_tick held high so that the width in clocks equals the width in ticks, including the full 0xFFFC-tick pulse.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int unsigned CW = 16;
  typedef logic [CW-1:0] cnt_t;
  typedef logic [3:0]    addr_t;

  typedef enum logic [1:0] {
    CKS_DIV2 = 2'd0,
    CKS_DIV4 = 2'd1,
    CKS_DIV8 = 2'd2,
    CKS_EXT  = 2'd3
  } cks_e;

  localparam addr_t A_CTLA  = 4'd0;
  localparam addr_t A_CTLB  = 4'd1;
  localparam addr_t A_STAT  = 4'd2;
  localparam addr_t A_CNTH  = 4'd3;
  localparam addr_t A_CNTL  = 4'd4;
  localparam addr_t A_CMP1H = 4'd5;
  localparam addr_t A_CMP1L = 4'd6;
  localparam addr_t A_CMP2H = 4'd7;
  localparam addr_t A_CMP2L = 4'd8;
  localparam addr_t A_CAPH  = 4'd9;
  localparam addr_t A_CAPL  = 4'd10;

  // control A fields
  localparam int unsigned CA_LVL_AFT = 0;
  localparam int unsigned CA_LVL_DUR = 1;
  localparam int unsigned CA_FRC1    = 2;
  localparam int unsigned CA_FRC2    = 3;
  localparam int unsigned CA_RISE    = 4;
  localparam int unsigned CA_CAPIE_G = 5;
  localparam int unsigned CA_CMPIE   = 6;
  // control B fields
  localparam int unsigned CB_OE1     = 0;
  localparam int unsigned CB_OE2     = 1;
  localparam int unsigned CB_ONEP    = 2;
  localparam int unsigned CB_PWM     = 3;
  localparam int unsigned CB_CKS_LO  = 4;
  localparam int unsigned CB_CAPIE_1 = 6;
  // status fields
  localparam int unsigned ST_CAP  = 0;
  localparam int unsigned ST_CMP1 = 1;
  localparam int unsigned ST_CMP2 = 2;
endpackage

// File: rtl/occ_rst_sync.sv
module occ_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/occ_prescaler.sv
module occ_prescaler #(
  parameter int unsigned PRE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       ext_tick,
  output logic       tick
);
  import occ_pkg::*;
  localparam int unsigned N_DIV = 3;

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] div_d;
  logic [N_DIV-1:0] term;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // term[k] fires once every 2^(k+1) clocks
  for (genvar k = 0; k < N_DIV; k++) begin : g_term
    assign term[k] = &div_q[k:0];
  end

  always_comb begin
    unique case (cks_e'(sel))
      CKS_DIV2: tick = term[0];
      CKS_DIV4: tick = term[1];
      CKS_DIV8: tick = term[2];
      default:  tick = ext_tick;
    endcase
  end
endmodule

// File: rtl/occ_capture.sv
module occ_capture #(
  parameter int unsigned W    = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic         rise_sel,
  input  logic         rd_hi,
  input  logic         rd_lo,
  input  logic         take,
  input  logic [W-1:0] val,
  output logic         edge_act,
  output logic         locked,
  output logic [W-1:0] cap_q
);
  logic [SYNC-1:0] sync_q, sync_d;
  logic            prev_q;
  logic            lock_q, lock_d;
  logic [W-1:0]    cap_d;
  logic            lvl;

  assign lvl = sync_q[SYNC-1];

  always_comb begin
    sync_d = {sync_q[SYNC-2:0], pin};
    lock_d = lock_q;
    if (rd_hi)      lock_d = 1'b1;
    else if (rd_lo) lock_d = 1'b0;
    cap_d = take ? val : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      lock_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= lvl;
      lock_q <= lock_d;
      cap_q  <= cap_d;
    end
  end

  assign edge_act = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);
  assign locked   = lock_q;
endmodule

// File: rtl/occ_compare.sv
module occ_compare #(
  parameter int unsigned W     = 16,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [7:0]   wdata,
  input  logic         tick,
  input  logic [W-1:0] cnt_next,
  output logic [W-1:0] cmp_q,
  output logic         locked,
  output logic         hit
);
  localparam int unsigned HI_W = W - 8;

  logic [W-1:0] cmp_d;
  logic         lock_q, lock_d;

  always_comb begin
    cmp_d  = cmp_q;
    lock_d = lock_q;
    if (wr_hi) begin
      cmp_d  = {wdata[HI_W-1:0], cmp_q[7:0]};
      lock_d = 1'b1;
    end else if (wr_lo) begin
      cmp_d  = {cmp_q[W-1:8], wdata};
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= RST_VAL;
      lock_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      lock_q <= lock_d;
    end
  end

  // match on the clock at which the counter advances onto the value
  assign hit    = tick & ~lock_q & (cnt_next == cmp_q);
  assign locked = lock_q;
endmodule

// File: rtl/occ_timer.sv
module occ_timer
  import occ_pkg::*;
#(
  parameter int unsigned PRE_W     = 3,
  parameter int unsigned SYNC      = 2,
  parameter int unsigned RST_STG   = 2,
  parameter logic [15:0] RELOAD    = 16'hFFFC,
  parameter logic [6:0]  CTLB_RST  = 7'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cap_in,
  input  logic       ext_tick,
  output logic       cmp1_out,
  output logic       cmp2_out,
  output logic       irq
);
  localparam int unsigned N_CMP = 2;
  localparam int unsigned N_ST  = 3;
  localparam cnt_t        WRAP_END = cnt_t'(RELOAD + RELOAD);

  logic rst_i_n;
  occ_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  // ---------------- registers ----------------
  logic [6:0]      ctla_q, ctla_d, ctlb_q, ctlb_d;
  logic [N_ST-1:0] stat_q, stat_d;
  cnt_t            cnt_q, cnt_d, cnt_inc;
  logic            pulse_q, pulse_d;
  logic            pin1_q, pin1_d, pin2_q, pin2_d;

  // ---------------- field decode ----------------
  logic lvl1, lvl2, frc1, frc2, rise, capie_g, cmpie;
  logic oe1, oe2, opm_on, pwm_on, capie_1;
  logic [1:0] cks;
  assign lvl1    = ctla_q[CA_LVL_AFT];
  assign lvl2    = ctla_q[CA_LVL_DUR];
  assign frc1    = ctla_q[CA_FRC1];
  assign frc2    = ctla_q[CA_FRC2];
  assign rise    = ctla_q[CA_RISE];
  assign capie_g = ctla_q[CA_CAPIE_G];
  assign cmpie   = ctla_q[CA_CMPIE];
  assign oe1     = ctlb_q[CB_OE1];
  assign oe2     = ctlb_q[CB_OE2];
  assign opm_on  = ctlb_q[CB_ONEP];
  assign pwm_on  = ctlb_q[CB_PWM];
  assign cks     = ctlb_q[CB_CKS_LO +: 2];
  assign capie_1 = ctlb_q[CB_CAPIE_1];

  // ---------------- access strobes ----------------
  logic wr_ctla, wr_ctlb, wr_stat, rd_caph, rd_capl;
  assign wr_ctla = reg_wr && (reg_addr == A_CTLA);
  assign wr_ctlb = reg_wr && (reg_addr == A_CTLB);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign rd_caph = reg_rd && (reg_addr == A_CAPH);
  assign rd_capl = reg_rd && (reg_addr == A_CAPL);

  // ---------------- tick source ----------------
  logic tick;
  occ_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .sel(cks), .ext_tick(ext_tick), .tick(tick)
  );

  // ---------------- capture channel ----------------
  logic cap_edge, cap_lock, cap_take, opm_sel, opm_go;
  cnt_t cap_q, cap_val;

  assign opm_sel  = opm_on & ~pwm_on;
  assign cap_take = cap_edge & ~cap_lock;
  assign opm_go   = opm_sel & cap_take;
  assign cap_val  = opm_go ? RELOAD : cnt_q;

  occ_capture #(.W(CW), .SYNC(SYNC)) u_cap (
    .clk(clk), .rst_n(rst_i_n), .pin(cap_in), .rise_sel(rise),
    .rd_hi(rd_caph), .rd_lo(rd_capl), .take(cap_take), .val(cap_val),
    .edge_act(cap_edge), .locked(cap_lock), .cap_q(cap_q)
  );

  // ---------------- compare channels ----------------
  cnt_t             cmp_val [N_CMP];
  logic [N_CMP-1:0] cmp_lock, cmp_hit;

  assign cnt_inc = cnt_q + 1'b1;

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    logic wr_hi_i, wr_lo_i;
    assign wr_hi_i = reg_wr && (reg_addr == addr_t'(A_CMP1H + addr_t'(2 * i)));
    assign wr_lo_i = reg_wr && (reg_addr == addr_t'(A_CMP1L + addr_t'(2 * i)));
    occ_compare #(.W(CW)) u_cmp (
      .clk(clk), .rst_n(rst_i_n), .wr_hi(wr_hi_i), .wr_lo(wr_lo_i),
      .wdata(reg_wdata), .tick(tick), .cnt_next(cnt_inc),
      .cmp_q(cmp_val[i]), .locked(cmp_lock[i]), .hit(cmp_hit[i])
    );
  end

  // pulse end: a reload-valued compare spans a full reload-length pulse
  cnt_t opm_target;
  logic opm_end;
  assign opm_target = (cmp_val[0] == RELOAD) ? WRAP_END : cmp_val[0];
  assign opm_end    = pulse_q & opm_sel & ~cmp_lock[0] & tick & (cnt_inc == opm_target);

  // ---------------- next state ----------------
  always_comb begin
    ctla_d = wr_ctla ? reg_wdata[6:0] : ctla_q;
    ctlb_d = wr_ctlb ? reg_wdata[6:0] : ctlb_q;

    if (opm_go)    cnt_d = RELOAD;
    else if (tick) cnt_d = cnt_inc;
    else           cnt_d = cnt_q;

    if (!opm_sel)     pulse_d = 1'b0;
    else if (opm_go)  pulse_d = 1'b1;
    else if (opm_end) pulse_d = 1'b0;
    else              pulse_d = pulse_q;

    pin1_d = pin1_q;
    if (opm_sel) begin
      if (opm_go)       pin1_d = lvl2;
      else if (opm_end) pin1_d = lvl1;
    end else if (frc1 && !pwm_on) begin
      pin1_d = lvl1;
    end else if (cmp_hit[0]) begin
      pin1_d = lvl1;
    end

    pin2_d = pin2_q;
    if (frc2)            pin2_d = lvl2;
    else if (cmp_hit[1]) pin2_d = lvl2;

    stat_d = stat_q;
    if (wr_stat) stat_d = stat_q & ~reg_wdata[N_ST-1:0];
    if (cap_take)               stat_d[ST_CAP]  = 1'b1;
    if (cmp_hit[0] && !opm_sel) stat_d[ST_CMP1] = 1'b1;
    if (cmp_hit[1])             stat_d[ST_CMP2] = 1'b1;
  end

  // ---------------- state registers ----------------
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctla_q  <= '0;
      ctlb_q  <= CTLB_RST;
      stat_q  <= '0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      pin1_q  <= 1'b0;
      pin2_q  <= 1'b0;
    end else begin
      ctla_q  <= ctla_d;
      ctlb_q  <= ctlb_d;
      stat_q  <= stat_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      pin1_q  <= pin1_d;
      pin2_q  <= pin2_d;
    end
  end

  // ---------------- outputs ----------------
  assign cmp1_out = oe1 & pin1_q;
  assign cmp2_out = oe2 & pin2_q;
  assign irq = (stat_q[ST_CAP] & (capie_g | capie_1))
             | (cmpie & (stat_q[ST_CMP1] | stat_q[ST_CMP2]));

  always_comb begin
    unique case (reg_addr)
      A_CTLA:  reg_rdata = {1'b0, ctla_q};
      A_CTLB:  reg_rdata = {1'b0, ctlb_q};
      A_STAT:  reg_rdata = {{(8-N_ST){1'b0}}, stat_q};
      A_CNTH:  reg_rdata = cnt_q[15:8];
      A_CNTL:  reg_rdata = cnt_q[7:0];
      A_CMP1H: reg_rdata = cmp_val[0][15:8];
      A_CMP1L: reg_rdata = cmp_val[0][7:0];
      A_CMP2H: reg_rdata = cmp_val[1][15:8];
      A_CMP2L: reg_rdata = cmp_val[1][7:0];
      A_CAPH:  reg_rdata = cap_q[15:8];
      A_CAPL:  reg_rdata = cap_q[7:0];
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/occ_timer_chk.sv
module occ_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        cap_edge,
  input logic        cap_lock,
  input logic        oc1_lock,
  input logic        opm_on,
  input logic        pwm_on,
  input logic        frc1,
  input logic        frc2,
  input logic        lvl1,
  input logic        lvl2,
  input logic [15:0] cnt_q,
  input logic [2:0]  stat_q,
  input logic        pin1_q,
  input logic        pin2_q
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(opm_on && !pwm_on && cap_edge && !cap_lock)) |=> $stable(cnt_q));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opm_on && !pwm_on && cap_edge && !cap_lock)
      |=> (cnt_q == 16'hFFFC && stat_q[0] && pin1_q == $past(lvl2)));

  assert_no_cmp1_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opm_on && !pwm_on && !stat_q[1]) |=> !stat_q[1]);

  assert_pwm_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_on && !tick) |=> $stable(cnt_q));

  assert_force1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frc1 && !opm_on && !pwm_on) |=> (pin1_q == $past(lvl1)));

  assert_force2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frc2 |=> (pin2_q == $past(lvl2)));

  assert_cmp_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oc1_lock && !stat_q[1]) |=> !stat_q[1]);

  assert_cap_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lock && !stat_q[0]) |=> !stat_q[0]);
endmodule

bind occ_timer occ_timer_chk u_chk (
  .clk(clk), .rst_n(rst_i_n), .tick(tick), .cap_edge(cap_edge),
  .cap_lock(cap_lock), .oc1_lock(cmp_lock[0]), .opm_on(opm_on),
  .pwm_on(pwm_on), .frc1(frc1), .frc2(frc2), .lvl1(lvl1), .lvl2(lvl2),
  .cnt_q(cnt_q), .stat_q(stat_q), .pin1_q(pin1_q), .pin2_q(pin2_q)
);

// File: tb/occ_timer_tb.sv
module occ_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam logic [3:0] T_CTLA = 0, T_CTLB = 1, T_STAT = 2, T_CNTH = 3, T_CNTL = 4,
                         T_C1H = 5, T_C1L = 6, T_C2H = 7, T_C2L = 8, T_CAPH = 9, T_CAPL = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] reg_addr;
  logic reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic cap_in, ext_tick;
  logic cmp1_out, cmp2_out, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  occ_timer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in), .ext_tick(ext_tick),
    .cmp1_out(cmp1_out), .cmp2_out(cmp2_out), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] ahi, output logic [15:0] v);
    logic [7:0] h, l;
    rd(ahi, h);
    rd(ahi + 4'd1, l);
    v = {h, l};
  endtask

  task automatic wr16(input logic [3:0] ahi, input logic [15:0] v);
    wr(ahi, v[15:8]);
    wr(ahi + 4'd1, v[7:0]);
  endtask

  task automatic cap_toggle();
    @(negedge clk); cap_in = 1'b1;
    repeat (5) @(negedge clk);
    cap_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic steps(input int n);
    @(negedge clk); ext_tick = 1'b1;
    repeat (n) @(negedge clk);
    ext_tick = 1'b0;
  endtask

  // one-pulse start with a rising edge, width counted in clocks at one tick per clock
  task automatic measure(output int w);
    bit seen;
    w = 0; seen = 0;
    @(negedge clk); cap_in = 1'b1;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (cmp1_out) begin seen = 1; w++; end
      else if (seen) break;
    end
    cap_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, a0, a1;
    logic [15:0] v, c;
    int w, exp_w;
    logic [15:0] oc;

    rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    cap_in = 0; ext_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // ---- R1 reset state
    rd16(T_CNTH, v); check("R1 counter", v, 16'h0000);
    rd(T_STAT, b);   check("R1 status", b, 8'h00);
    rd16(T_C1H, v);  check("R1 cmp1", v, 16'hFFFF);
    rd16(T_C2H, v);  check("R1 cmp2", v, 16'hFFFF);
    rd16(T_CAPH, v); check("R1 capture", v, 16'h0000);
    rd(T_CTLB, b);   check("R1 ctlb", b, 8'h30);
    rd(T_CTLA, b);   check("R1 ctla", b, 8'h00);
    check("R1 pins/irq", {cmp1_out, cmp2_out, irq}, 3'b000);

    // ---- R2 tick select sweep over 64 clocks
    for (int s = 0; s < 4; s++) begin
      wr(T_CTLB, 8'(s << 4));
      if (s == 3) ext_tick = 1'b1;
      rd(T_CNTL, a0);
      repeat (62) @(negedge clk);
      rd(T_CNTL, a1);
      check($sformatf("R2 advance sel=%0d", s), 8'(a1 - a0), (s == 3) ? 64 : (64 >> (s + 1)));
      ext_tick = 1'b0;
    end
    rd(T_CNTL, a0);
    repeat (20) @(negedge clk);
    rd(T_CNTL, a1);
    check("R2 hold without tick", a1, a0);

    // ---- R3/R4/R5 one-pulse width sweep, one tick per clock
    wr(T_CTLA, 8'h52);   // pulse level 1, after level 0, rising, compare irq
    wr(T_CTLB, 8'h37);   // pins on, one-pulse, external tick
    ext_tick = 1'b1;
    for (int n = 1; n <= 17; n++) begin
      oc = (n == 17) ? 16'h00FD : 16'(16'hFFFC + n);
      exp_w = int'(16'(oc - 16'hFFFC));
      wr16(T_C1H, oc);
      wr(T_STAT, 8'h07);
      measure(w);
      check($sformatf("R4 width cmp1=%0h", oc), w, exp_w);
      rd(T_STAT, b);
      check("R3 capture flag, R5 no cmp1 flag", b & 8'h03, 8'h01);
      rd16(T_CAPH, v);
      check("R3 capture holds reload", v, 16'hFFFC);
    end
    rd(T_STAT, b);
    check("R5 cmp2 flag in one-pulse", b, 8'h05);
    check("R5 irq from cmp2", irq, 1'b1);
    wr16(T_C1H, 16'hFFFC);
    wr(T_STAT, 8'h07);
    measure(w);
    check("R4 reload-valued compare width", w, 32'h0000FFFC);
    rd(T_STAT, b);
    check("R5 no cmp1 flag after full pulse", b[1], 1'b0);
    ext_tick = 1'b0;

    // ---- R6 PWM overrides one-pulse
    rd16(T_CNTH, c);
    wr(T_CTLB, 8'h3F);
    wr(T_STAT, 8'h07);
    cap_toggle();
    rd16(T_CNTH, v);  check("R6 no reload", v, c);
    rd16(T_CAPH, v);  check("R6 captures counter", v, c);
    rd(T_STAT, b);    check("R6 capture flag", b[0], 1'b1);
    check("R6 no pulse", cmp1_out, 1'b0);

    // ---- R9 capture interlock holds off one-pulse start
    wr(T_CTLB, 8'h37);
    rd(T_CAPH, b);
    wr(T_STAT, 8'h07);
    cap_toggle();
    rd16(T_CNTH, v);  check("R9 start held off", v, c);
    rd(T_STAT, b);    check("R9 no capture flag", b[0], 1'b0);
    check("R9 no pulse", cmp1_out, 1'b0);
    rd(T_CAPL, b);
    cap_toggle();
    rd16(T_CNTH, v);  check("R9 start after low read", v, 16'hFFFC);
    rd(T_STAT, b);    check("R9 capture flag after unlock", b[0], 1'b1);
    check("R3 pulse level on pin1", cmp1_out, 1'b1);

    // ---- R7 forced levels
    wr(T_STAT, 8'h07);
    wr(T_CTLA, 8'h16);  // force1 with after level 0, in one-pulse
    @(negedge clk);
    check("R7 force1 ignored in one-pulse", cmp1_out, 1'b1);
    wr(T_CTLA, 8'h1E);  // plus force2, pulse level 1
    @(negedge clk);
    check("R7 force2 works in one-pulse", cmp2_out, 1'b1);
    wr(T_CTLB, 8'h33);  // leave one-pulse
    @(negedge clk);
    check("R7 force1 drives after level 0", cmp1_out, 1'b0);
    wr(T_CTLA, 8'h1F);
    @(negedge clk);
    check("R7 force1 follows level 1", cmp1_out, 1'b1);
    wr(T_CTLA, 8'h1D);  // pulse level 0
    @(negedge clk);
    check("R7 force2 follows level 0", cmp2_out, 1'b0);
    rd(T_STAT, b);
    check("R7 forcing sets no flag", b, 8'h00);

    // ---- R12 output enables
    wr(T_CTLB, 8'h32);
    check("R12 pin1 disabled", cmp1_out, 1'b0);
    wr(T_CTLA, 8'h1F);
    @(negedge clk);
    wr(T_CTLB, 8'h31);
    check("R12 pin2 disabled", cmp2_out, 1'b0);
    check("R12 pin1 enabled", cmp1_out, 1'b1);

    // ---- R8 compare interlock
    wr(T_CTLA, 8'h10);
    wr(T_CTLB, 8'h37); cap_toggle(); wr(T_CTLB, 8'h33);
    wr(T_C1L, 8'hFE);
    wr(T_C1H, 8'hFF);          // locked
    wr(T_STAT, 8'h07);
    steps(2);
    rd16(T_CNTH, v);  check("R8 counter stepped", v, 16'hFFFE);
    rd(T_STAT, b);    check("R8 locked compare no flag", b[1], 1'b0);
    wr(T_C1L, 8'hFE);          // unlocked
    wr(T_CTLB, 8'h37); cap_toggle(); wr(T_CTLB, 8'h33);
    wr(T_STAT, 8'h07);
    steps(2);
    rd(T_STAT, b);    check("R8 unlocked compare flag", b[1], 1'b1);

    // ---- R11 interrupt and clear
    wr(T_CTLB, 8'h37); cap_toggle(); wr(T_CTLB, 8'h33);  // sets capture flag
    check("R11 no enable no irq", irq, 1'b0);
    wr(T_CTLA, 8'h50);
    check("R11 compare irq", irq, 1'b1);
    wr(T_STAT, 8'h02);
    rd(T_STAT, b);    check("R11 one-to-clear", b, 8'h01);
    check("R11 irq gone", irq, 1'b0);
    wr(T_CTLA, 8'h30);
    check("R11 global capture irq", irq, 1'b1);
    wr(T_CTLA, 8'h10);
    wr(T_CTLB, 8'h73);
    check("R11 channel capture irq", irq, 1'b1);
    wr(T_CTLB, 8'h33);
    check("R11 capture irq disabled", irq, 1'b0);

    // ---- R10 edge polarity
    wr(T_CTLA, 8'h00);
    wr(T_STAT, 8'h07);
    @(negedge clk); cap_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(T_STAT, b);    check("R10 rising ignored when falling selected", b[0], 1'b0);
    cap_in = 1'b0;
    repeat (5) @(negedge clk);
    rd(T_STAT, b);    check("R10 falling edge captured", b[0], 1'b1);
    rd16(T_CNTH, c);
    rd16(T_CAPH, v);  check("R10 capture value", v, c);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule